// File: doc/BRIEF.md
# Shared-Bus SRAM Write Sequencer

This block sits between a simple host request port and an asynchronous static RAM that captures its address and its second select when chip enable falls. It turns each accepted host request into the strobe sequence the memory needs. It presents the address with the second select low. It drops chip enable and the first select together. It lowers write enable and keeps the shared data bus undriven for an output-disable gap. It drives the write data. It ends the word by raising chip enable and the first select on the same clock that it releases the bus. A precharge interval with both strobes high follows.

Two further modes are supported. A request with the burst-continue flag set keeps write enable low through its precharge. A following write then skips the output-disable gap. A read-modify-write request first holds write enable high with the memory enabled for a programmable output-enable delay. At the end of that delay it samples the bus, reports the value one clock later, and then runs the normal write portion within the same enabled cycle. Every interval is a parameter counted in system clocks, and a value of zero is treated as one.

Top module: `sram_strobe_seq`

## Requirements
- R1: After acceptance, `mem_addr` carries the request address and `mem_latch_n` is low, with `mem_en_n` and `mem_cs_n` high, for T_ADDR clocks. `mem_addr` holds that address unchanged while enable falls and for as long as enable stays low.
- R2: `mem_en_n` and `mem_cs_n` always fall together at the end of the address phase and rise together at the end of the data phase.
- R3: A write (`req_op`=0) lowers `mem_we_n` when enable falls and keeps `mem_dq_oe` low for T_ODIS clocks. It then drives `mem_dq_o` = request data with `mem_dq_oe` high for T_DRIVE clocks.
- R4: `mem_dq_oe` falls on the same clock that `mem_en_n` and `mem_cs_n` rise, and enable never rises while the bus is still driven.
- R5: A request with `req_burst`=1 keeps `mem_we_n` low through its precharge and the idle cycles after it. If the next request is a write, that write drives data as soon as enable falls, with no output-disable gap. If the next request is a read-modify-write, `mem_we_n` returns high in its address phase.
- R6: A read-modify-write (`req_op`=1) holds `mem_we_n` high for T_RDEN clocks with enable low, samples `mem_dq_i` on the last of those clocks, and then runs the write portion of R3. `rd_valid` is high for exactly one clock, one clock after the sampling edge, and `rd_data` then holds the sampled word.
- R7: After each word, `mem_en_n`, `mem_cs_n` and `mem_latch_n` stay high for T_PRE clocks before the block becomes ready again.
- R8: `req_ready` is low from the clock after acceptance until precharge ends, and high in idle.
- R9: `mem_dq_oe` is high only while `mem_we_n`, `mem_en_n` and `mem_cs_n` are all low.
- R10: During and after reset, `req_ready` is 1, `mem_en_n`, `mem_cs_n`, `mem_latch_n` and `mem_we_n` are 1, and `mem_dq_oe` and `rd_valid` are 0.
- R11: At the rising enable edge, the word held in the memory at the request address equals the request data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 1 | 0 = write, 1 = read-modify-write |
| req_burst | input | 1 | Keep write enable low after this word |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| rd_valid | output | 1 | One-clock pulse: rd_data holds the sampled word |
| rd_data | output | DATA_W | Word read in a read-modify-write |
| mem_addr | output | ADDR_W | Memory address |
| mem_en_n | output | 1 | Chip enable, active low |
| mem_cs_n | output | 1 | First select, active low |
| mem_latch_n | output | 1 | Second select, low while the address is captured |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Data driven onto the shared bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_i | input | DATA_W | Data seen on the shared bus |

## Verification
Each request is accepted at a clock edge. From the next cycle on, the bench works out every strobe level from the phase lengths: T_ADDR address clocks, then T_RDEN read clocks for a read-modify-write, then T_ODIS gap clocks unless a held write enable removes the gap, then T_DRIVE drive clocks, then T_PRE precharge clocks. It compares the ports at the falling clock edge in each of those cycles. `rd_valid` is due in the cycle that starts two edges after the last read clock begins, offset T_ADDR+T_RDEN+1 counted from the first cycle after acceptance, and must be low in every other cycle. The memory contents and `req_ready` are checked in the first idle cycle after precharge. By then the bench memory model has committed the word at the rising enable edge.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_RMW   = 1'b1
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RDWAIT,
        ST_ODIS,
        ST_DRIVE,
        ST_PRE
    } st_e;

    typedef struct packed {
        logic en_n;
        logic cs_n;
        logic latch_n;
        logic we_n;
        logic oe;
    } strobe_t;

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d,
                                         input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/seq_rdcap.sv
module seq_rdcap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          samp,
    input  logic [DW-1:0] dq_i,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic samp_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_d   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            samp_d   <= samp;
            rd_valid <= samp_d;
            if (samp) rd_data <= dq_i;
        end
    end

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $stable(rd_data));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int CW      = 2,
    parameter int D_ADDR  = 1,
    parameter int D_RDEN  = 1,
    parameter int D_ODIS  = 1,
    parameter int D_DRIVE = 1,
    parameter int D_PRE   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic          req_burst,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output strobe_t       strb,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          samp
);
    st_e           state_q, state_d;
    op_e           op_q;
    logic          burst_q, hold_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          skip_gap;

    assign skip_gap = hold_q && (op_q == OP_WRITE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ADDR;
            ST_ADDR:   if (tmr_zero) begin
                           if (op_q == OP_RMW) state_d = ST_RDWAIT;
                           else if (skip_gap)  state_d = ST_DRIVE;
                           else                state_d = ST_ODIS;
                       end
            ST_RDWAIT: if (tmr_zero) state_d = ST_ODIS;
            ST_ODIS:   if (tmr_zero) state_d = ST_DRIVE;
            ST_DRIVE:  if (tmr_zero) state_d = ST_PRE;
            ST_PRE:    if (tmr_zero) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_ADDR:   tmr_val = CW'(D_ADDR - 1);
            ST_RDWAIT: tmr_val = CW'(D_RDEN - 1);
            ST_ODIS:   tmr_val = CW'(D_ODIS - 1);
            ST_DRIVE:  tmr_val = CW'(D_DRIVE - 1);
            ST_PRE:    tmr_val = CW'(D_PRE - 1);
            default:   tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_WRITE;
            burst_q <= 1'b0;
            hold_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                op_q    <= op_e'(req_op);
                burst_q <= req_burst;
                addr_q  <= req_addr;
                data_q  <= req_wdata;
            end
            if (state_q == ST_PRE && tmr_zero) hold_q <= burst_q;
        end
    end

    always_comb begin
        strb = '{en_n: 1'b1, cs_n: 1'b1, latch_n: 1'b1, we_n: ~hold_q, oe: 1'b0};
        unique case (state_q)
            ST_ADDR: begin
                strb.latch_n = 1'b0;
                strb.we_n    = ~skip_gap;
            end
            ST_RDWAIT: strb = '{en_n: 1'b0, cs_n: 1'b0, latch_n: 1'b0, we_n: 1'b1, oe: 1'b0};
            ST_ODIS:   strb = '{en_n: 1'b0, cs_n: 1'b0, latch_n: 1'b0, we_n: 1'b0, oe: 1'b0};
            ST_DRIVE:  strb = '{en_n: 1'b0, cs_n: 1'b0, latch_n: 1'b0, we_n: 1'b0, oe: 1'b1};
            ST_PRE:    strb.we_n = ~burst_q;
            default:   ;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign addr_o    = addr_q;
    assign data_o    = data_q;
    assign samp      = (state_q == ST_RDWAIT) && tmr_zero;

    // R6
    rmw_sample_chk: assert property (@(posedge clk) disable iff (rst)
        samp |-> (op_q == OP_RMW) && !strb.en_n && strb.we_n);

    // R5
    gap_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRIVE && $past(state_q) == ST_ADDR) |-> $past(hold_q) && (op_q == OP_WRITE));
endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int T_ADDR  = 1,
    parameter int T_RDEN  = 2,
    parameter int T_ODIS  = 1,
    parameter int T_DRIVE = 2,
    parameter int T_PRE   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en_n,
    output logic              mem_cs_n,
    output logic              mem_latch_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned DA = at_least_one(T_ADDR);
    localparam int unsigned DR = at_least_one(T_RDEN);
    localparam int unsigned DO = at_least_one(T_ODIS);
    localparam int unsigned DD = at_least_one(T_DRIVE);
    localparam int unsigned DP = at_least_one(T_PRE);
    localparam int unsigned DMAX = max5(DA, DR, DO, DD, DP);
    localparam int CW = (DMAX > 1) ? $clog2(DMAX) : 1;

    logic          tmr_zero, tmr_load, samp;
    logic [CW-1:0] tmr_val;
    strobe_t       strb;

    seq_ctrl #(
        .AW(ADDR_W), .DW(DATA_W), .CW(CW),
        .D_ADDR(DA), .D_RDEN(DR), .D_ODIS(DO), .D_DRIVE(DD), .D_PRE(DP)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_burst(req_burst),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .strb(strb), .addr_o(mem_addr), .data_o(mem_dq_o), .samp(samp)
    );

    seq_delay #(.CW(CW)) u_delay (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    seq_rdcap #(.DW(DATA_W)) u_rdcap (
        .clk(clk), .rst(rst), .samp(samp), .dq_i(mem_dq_i),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign mem_en_n    = strb.en_n;
    assign mem_cs_n    = strb.cs_n;
    assign mem_latch_n = strb.latch_n;
    assign mem_we_n    = strb.we_n;
    assign mem_dq_oe   = strb.oe;

    // R1
    addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_en_n) |-> $stable(mem_addr) && !mem_latch_n);

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_addr));

    // R2
    strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en_n == mem_cs_n);

    // R4
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_en_n) |-> !mem_dq_oe && $past(mem_dq_oe));

    // R9
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n && !mem_en_n && !mem_cs_n);

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_en_n && !mem_dq_oe);

    // R7
    precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> $past(mem_en_n) && $past(mem_latch_n));

    // R6
    rdvalid_window_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !mem_en_n && !mem_we_n);
endmodule

// File: tb/sim_sram_strobe_seq.sv
module sim_sram_strobe_seq;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int TA = 2;
    localparam int TR = 3;
    localparam int TO = 2;
    localparam int TD = 2;
    localparam int TP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_op = 1'b0, req_burst = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid, mem_en_n, mem_cs_n, mem_latch_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0, fails = 0;
    bit done = 0, held = 0;

    always #2 clk = ~clk;

    sram_strobe_seq #(.ADDR_W(AW), .DATA_W(DW), .T_ADDR(TA), .T_RDEN(TR),
                      .T_ODIS(TO), .T_DRIVE(TD), .T_PRE(TP)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_en_n(mem_en_n),
        .mem_cs_n(mem_cs_n), .mem_latch_n(mem_latch_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // memory model
    logic [DW-1:0] mem_m  [0:(1<<AW)-1];
    logic [DW-1:0] shadow [0:(1<<AW)-1];
    logic [AW-1:0] lat_a = '0;
    logic [DW-1:0] pend_d = '0;
    bit            pend = 0;
    logic          en_prev = 1'b1;

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(i * 173 + 41);
    endfunction

    always @(negedge mem_en_n) lat_a = mem_addr;
    assign mem_dq_i = (!mem_en_n && !mem_cs_n && mem_we_n) ? mem_m[lat_a] : 16'hBEEF;

    always @(negedge clk) begin
        if (!mem_en_n && !mem_cs_n && !mem_we_n && mem_dq_oe) begin
            pend_d = mem_dq_o;
            pend   = 1;
        end
        if (pend && mem_en_n && !en_prev) begin
            mem_m[lat_a] = pend_d;
            pend = 0;
        end
        en_prev = mem_en_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] pins();
        return {req_ready, mem_latch_n, mem_en_n, mem_cs_n, mem_we_n, mem_dq_oe};
    endfunction

    // expected vector {ready, latch_n, en_n, cs_n, we_n, oe}
    function automatic logic [5:0] vec(input bit rdy, input bit lat, input bit en, input bit we, input bit oe);
        return {rdy, lat, en, en, we, oe};
    endfunction

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            chk(pins() == vec(1, 1, 1, !held, 0), "R8 idle strobes", 32'(pins()), 32'(vec(1, 1, 1, !held, 0)));
            @(negedge clk);
        end
    endtask

    task automatic run_txn(input bit op, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit b);
        bit skip;
        int p0, p1, p2, p3, p4;
        logic [5:0] e;
        string r;
        skip = held && !op;
        p0 = TA;
        p1 = p0 + (op ? TR : 0);
        p2 = p1 + (skip ? 0 : TO);
        p3 = p2 + TD;
        p4 = p3 + TP;
        req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_burst = b;
        @(negedge clk);
        req_valid = 0; req_wdata = ~d; req_addr = ~a;
        for (int k = 0; k < p4; k++) begin
            if (k < p0) begin
                e = vec(0, 0, 1, !(held && !op), 0); r = "R1 address phase";
            end else if (k < p1) begin
                e = vec(0, 0, 0, 1, 0); r = "R6 read window";
            end else if (k < p2) begin
                e = vec(0, 0, 0, 0, 0); r = "R3 output-disable gap";
            end else if (k < p3) begin
                e = vec(0, 0, 0, 0, 1); r = (skip && k == p2) ? "R5 no gap after held we" : "R3 drive";
                chk(mem_dq_o == d, "R3 write data", 32'(mem_dq_o), 32'(d));
            end else begin
                e = vec(0, 1, 1, !b, 0); r = (k == p3) ? "R4 release with rising enable" : "R7 precharge";
            end
            chk(pins() == e, r, 32'(pins()), 32'(e));
            if (k < p3) chk(mem_addr == a, "R1 address stable", 32'(mem_addr), 32'(a));
            chk(rd_valid == (op && k == p1 + 1), "R6 rd_valid timing", 32'(rd_valid), 32'(op && k == p1 + 1));
            if (op && k == p1 + 1) chk(rd_data == shadow[a], "R6 read data", 32'(rd_data), 32'(shadow[a]));
            @(negedge clk);
        end
        #1;
        chk(req_ready == 1'b1, "R8 ready after precharge", 32'(req_ready), 32'd1);
        chk(mem_we_n == !b, "R5 we level after word", 32'(mem_we_n), 32'(!b));
        chk(mem_m[a] == d, "R11 memory content", 32'(mem_m[a]), 32'(d));
        shadow[a] = d;
        held = b;
    endtask

    initial begin
        int unsigned seed;
        for (int i = 0; i < (1 << AW); i++) begin
            mem_m[i]  = init_word(i);
            shadow[i] = init_word(i);
        end
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk(pins() == vec(1, 1, 1, 1, 0), "R10 reset strobes", 32'(pins()), 32'(vec(1, 1, 1, 1, 0)));
        chk(rd_valid == 1'b0, "R10 reset rd_valid", 32'(rd_valid), 32'd0);
        rst = 0;
        @(negedge clk);
        chk(pins() == vec(1, 1, 1, 1, 0), "R10 after reset", 32'(pins()), 32'(vec(1, 1, 1, 1, 0)));
        // directed cases
        run_txn(0, 6'd3, 16'h1234, 0);
        idle_cycles(2);
        run_txn(1, 6'd3, 16'hABCD, 0);
        run_txn(0, 6'd10, 16'h0F0F, 1);
        run_txn(0, 6'd11, 16'h5A5A, 1);
        idle_cycles(3);
        run_txn(0, 6'd12, 16'hC3C3, 1);
        run_txn(1, 6'd10, 16'h7777, 1);
        run_txn(0, 6'd13, 16'h2468, 0);
        run_txn(1, 6'd63, 16'hFFFF, 0);
        // random mix
        for (int n = 0; n < 60; n++) begin
            idle_cycles($urandom % 3);
            run_txn(($urandom % 3) == 0, AW'($urandom), DW'($urandom), $urandom % 2);
        end
        idle_cycles(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule